// File: doc/BRIEF.md
# ADC Conversion Start Controller

This block decides when an analog-to-digital converter begins a conversion and protects the two byte-wide registers that software reads the result from. A start comes either from a manual request or, when automatic triggering is on, from a hardware source picked by a 4-bit select field. That source can be a timer, external-interrupt or comparator event flag, taken on its rising edge. It can also be one of three flagless PWM synchronization pulses. A free-running mode restarts the converter after every completed conversion. The converter is modelled as a handshake: the block issues a one-cycle start pulse, reports itself busy, and waits for a done strobe that carries a 10-bit result.

The result guard stores each finished result as a low byte and a high byte. Reading the low byte freezes both bytes until the high byte is read, so a two-byte read always returns a matched pair.

Conversion sequencer states: `SEQ_IDLE` (waiting; a manual request or automatic event moves to `SEQ_BUSY` and fires the start pulse), `SEQ_BUSY` (conversion running; the done strobe moves to `SEQ_RELAUNCH` in free-running mode, otherwise to `SEQ_IDLE`), `SEQ_RELAUNCH` (one cycle; fires the start pulse and moves to `SEQ_BUSY`). Guard states: `GRD_OPEN` (results update; a low-byte read moves to `GRD_LOCKED`) and `GRD_LOCKED` (results frozen; a high-byte read moves back to `GRD_OPEN`).

Top module: `adc_trig_ctrl`

## Requirements
- R1: After reset, `soc` and `busy` are 0 and both result bytes read 0x00.
- R2: While `auto_en` is 0, flags and sync pulses cause no start. A manual `start_req` seen in idle drives `soc` high for exactly the next cycle, and `busy` goes high with it.
- R3: With `auto_en` set and a flag source selected, a rising edge of that flag starts a conversion in the following cycle. A flag held high starts nothing more, and unselected flags have no effect. Flag bit mapping: `evt_flag[0]` ext-int 0 (code 1), `[1]` timer0 compare (2), `[2]` timer0 overflow (3), `[3]` timer1 compare B (4), `[4]` timer1 overflow (5), `[5]` timer1 capture (6), `[6..9]` comparators 0..3 (codes 10..13).
- R4: Codes 7, 8 and 9 select `sync_pulse[0..2]`. Each cycle the selected pulse is high while the sequencer is idle starts a conversion. A pulse during a busy conversion is ignored.
- R5: Select codes 14 and 15 never produce an automatic start.
- R6: In the cycle the select code changes, no automatic start occurs. The edge detector takes the new source's present level, so a flag already high when selected does not start a conversion.
- R7: With `auto_en` set and code 0 (free-running), a done strobe in `busy` gives a new `soc` two cycles after the strobe cycle. Without such a strobe, only a manual request starts.
- R8: A start request or event while busy is dropped, not queued.
- R9: Each accepted done strobe stores the result: `res_lo` = bits 7:0 and `res_hi` = {6'b0, bits 9:8}, visible in the next cycle.
- R10: A `rd_lo` strobe locks both bytes from the next cycle on. A done strobe in the `rd_lo` cycle or while locked is lost. A `rd_hi` strobe while locked unlocks again.
- R11: A `rd_hi` strobe without a preceding `rd_lo` has no effect on later updates.
- R12: `soc` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_en | input | 1 | Automatic triggering enable |
| trig_sel | input | 4 | Trigger source select code |
| evt_flag | input | 10 | Event flag levels (timers, ext-int, comparators) |
| sync_pulse | input | 3 | PWM module synchronization pulses |
| start_req | input | 1 | Manual start request |
| conv_done | input | 1 | Conversion-complete strobe |
| conv_result | input | 10 | Result valid with `conv_done` |
| rd_lo | input | 1 | Low result byte read strobe |
| rd_hi | input | 1 | High result byte read strobe |
| soc | output | 1 | One-cycle start-of-conversion pulse |
| busy | output | 1 | Conversion in progress |
| res_lo | output | 8 | Low result byte |
| res_hi | output | 8 | High result byte |

## Verification
A stale edge-detector level shows up within one cycle of a select change or a flag edge: either `soc` appears with no fresh edge, or an expected pulse is missing. A sequencer stuck in the wrong state shows on `busy`, and as a missing or doubled `soc` on the next request or done strobe. A guard left locked or unlocked in error shows the cycle after the next done strobe, as bytes that changed when frozen or stayed frozen after the high read.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
    localparam int SEL_W      = 4;
    localparam int RES_W      = 10;
    localparam int LO_W       = 8;
    localparam int N_TMR_FLAG = 6;
    localparam int N_SYNC     = 3;
    localparam int N_CMP      = 4;
    localparam int N_FLAG     = N_TMR_FLAG + N_CMP;

    typedef enum logic [1:0] {
        SEQ_IDLE     = 2'd0,
        SEQ_BUSY     = 2'd1,
        SEQ_RELAUNCH = 2'd2
    } seq_state_t;

    typedef enum logic {
        GRD_OPEN   = 1'b0,
        GRD_LOCKED = 1'b1
    } grd_state_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_FLAG = 2'd1,
        SRC_SYNC = 2'd2
    } src_kind_t;
endpackage

// File: rtl/adc_trig_src_sel.sv
module adc_trig_src_sel
    import adc_trig_pkg::*;
#(
    parameter int SW     = SEL_W,
    parameter int NTF    = N_TMR_FLAG,
    parameter int NSY    = N_SYNC,
    parameter int NCM    = N_CMP
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               auto_en,
    input  logic [SW-1:0]      trig_sel,
    input  logic [NTF+NCM-1:0] evt_flag,
    input  logic [NSY-1:0]     sync_pulse,
    input  logic               idle,
    output logic               auto_evt
);
    localparam int SYNC_BASE = NTF + 1;
    localparam int CMP_BASE  = NTF + NSY + 1;

    src_kind_t     kind;
    logic          lvl;
    logic [SW-1:0] sel_q;
    logic          prev_lvl;
    logic          sel_changed;
    logic          flag_edge;
    logic          sync_hit;

    // decode the select code into a source class and its present level
    always_comb begin
        kind = SRC_NONE;
        lvl  = 1'b0;
        for (int i = 0; i < NTF; i++) begin
            if (trig_sel == SW'(i + 1)) begin
                kind = SRC_FLAG;
                lvl  = evt_flag[i];
            end
        end
        for (int i = 0; i < NSY; i++) begin
            if (trig_sel == SW'(SYNC_BASE + i)) begin
                kind = SRC_SYNC;
                lvl  = sync_pulse[i];
            end
        end
        for (int i = 0; i < NCM; i++) begin
            if (trig_sel == SW'(CMP_BASE + i)) begin
                kind = SRC_FLAG;
                lvl  = evt_flag[NTF + i];
            end
        end
    end

    // the detector always follows the selected source, so a new code starts clean
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= '0;
            prev_lvl <= 1'b0;
        end else begin
            sel_q    <= trig_sel;
            prev_lvl <= lvl;
        end
    end

    assign sel_changed = (trig_sel != sel_q);
    assign flag_edge   = (kind == SRC_FLAG) && lvl && !prev_lvl && !sel_changed;
    assign sync_hit    = (kind == SRC_SYNC) && lvl && idle && !sel_changed;
    assign auto_evt    = auto_en && (flag_edge || sync_hit);
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
    import adc_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic auto_evt,
    input  logic free_run,
    input  logic conv_done,
    output logic soc,
    output logic busy,
    output logic idle
);
    seq_state_t state, state_nx;
    logic       launch;

    always_comb begin
        state_nx = state;
        launch   = 1'b0;
        unique case (state)
            SEQ_IDLE: begin
                if (start_req || auto_evt) begin
                    launch   = 1'b1;
                    state_nx = SEQ_BUSY;
                end
            end
            SEQ_BUSY: begin
                if (conv_done) begin
                    state_nx = free_run ? SEQ_RELAUNCH : SEQ_IDLE;
                end
            end
            SEQ_RELAUNCH: begin
                launch   = 1'b1;
                state_nx = SEQ_BUSY;
            end
            default: state_nx = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) soc <= 1'b0;
        else        soc <= launch;
    end

    assign busy = (state == SEQ_BUSY);
    assign idle = (state == SEQ_IDLE);
endmodule

// File: rtl/adc_result_guard.sv
module adc_result_guard
    import adc_trig_pkg::*;
#(
    parameter int RW = RES_W,
    parameter int BW = LO_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conv_done,
    input  logic [RW-1:0] conv_result,
    input  logic          rd_lo,
    input  logic          rd_hi,
    output logic [BW-1:0] res_lo,
    output logic [BW-1:0] res_hi,
    output logic          locked
);
    localparam int HI_BITS = RW - BW;
    localparam int HI_PAD  = BW - HI_BITS;

    grd_state_t    state, state_nx;
    logic [RW-1:0] res_q;
    logic          capture;

    always_comb begin
        state_nx = state;
        unique case (state)
            GRD_OPEN:   if (rd_lo) state_nx = GRD_LOCKED;
            GRD_LOCKED: if (rd_hi) state_nx = GRD_OPEN;
            default:    state_nx = GRD_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= GRD_OPEN;
        else        state <= state_nx;
    end

    // a done strobe in the cycle of the low read already belongs to the lock
    assign capture = conv_done && (state == GRD_OPEN) && !rd_lo;

    always_ff @(posedge clk) begin
        if (!rst_n)       res_q <= '0;
        else if (capture) res_q <= conv_result;
    end

    assign res_lo = res_q[BW-1:0];
    assign res_hi = {{HI_PAD{1'b0}}, res_q[RW-1:BW]};
    assign locked = (state == GRD_LOCKED);
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
    import adc_trig_pkg::*;
#(
    parameter int SW  = SEL_W,
    parameter int RW  = RES_W,
    parameter int BW  = LO_W,
    parameter int NTF = N_TMR_FLAG,
    parameter int NSY = N_SYNC,
    parameter int NCM = N_CMP
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               auto_en,
    input  logic [SW-1:0]      trig_sel,
    input  logic [NTF+NCM-1:0] evt_flag,
    input  logic [NSY-1:0]     sync_pulse,
    input  logic               start_req,
    input  logic               conv_done,
    input  logic [RW-1:0]      conv_result,
    input  logic               rd_lo,
    input  logic               rd_hi,
    output logic               soc,
    output logic               busy,
    output logic [BW-1:0]      res_lo,
    output logic [BW-1:0]      res_hi
);
    logic auto_evt;
    logic seq_idle;
    logic free_run;
    logic guard_locked;

    assign free_run = auto_en && (trig_sel == '0);

    adc_trig_src_sel #(.SW(SW), .NTF(NTF), .NSY(NSY), .NCM(NCM)) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_en    (auto_en),
        .trig_sel   (trig_sel),
        .evt_flag   (evt_flag),
        .sync_pulse (sync_pulse),
        .idle       (seq_idle),
        .auto_evt   (auto_evt)
    );

    adc_trig_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .auto_evt  (auto_evt),
        .free_run  (free_run),
        .conv_done (conv_done),
        .soc       (soc),
        .busy      (busy),
        .idle      (seq_idle)
    );

    adc_result_guard #(.RW(RW), .BW(BW)) u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .rd_lo       (rd_lo),
        .rd_hi       (rd_hi),
        .res_lo      (res_lo),
        .res_hi      (res_hi),
        .locked      (guard_locked)
    );
endmodule

// File: rtl/adc_trig_ctrl_chk.sv
module adc_trig_ctrl_chk #(
    parameter int SW = 4,
    parameter int BW = 8,
    parameter int RW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          auto_en,
    input logic [SW-1:0] trig_sel,
    input logic          conv_done,
    input logic          rd_lo,
    input logic          rd_hi,
    input logic          soc,
    input logic          busy,
    input logic [BW-1:0] res_lo,
    input logic [BW-1:0] res_hi,
    input logic          auto_evt,
    input logic          guard_locked
);
    localparam int HI_PAD = 2 * BW - RW;

    a_r12_soc_single: assert property (@(posedge clk) disable iff (!rst_n)
        soc |=> !soc);

    a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !conv_done) |=> !soc);

    a_r2_auto_off: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |-> !auto_evt);

    a_r5_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel >= SW'(14)) |-> !auto_evt);

    a_r6_sel_change_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel != $past(trig_sel)) |-> !auto_evt);

    a_r7_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_done && auto_en && trig_sel == '0) |=> ##1 soc);

    a_r10_lock_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!guard_locked && rd_lo) |=> guard_locked);

    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        guard_locked |=> ($stable(res_lo) && $stable(res_hi)));

    a_r11_hi_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (!guard_locked && !rd_lo) |=> !guard_locked);

    a_r9_hi_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        res_hi[BW-1:BW-HI_PAD] == '0);
endmodule

bind adc_trig_ctrl adc_trig_ctrl_chk #(.SW(SW), .BW(BW), .RW(RW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .auto_en      (auto_en),
    .trig_sel     (trig_sel),
    .conv_done    (conv_done),
    .rd_lo        (rd_lo),
    .rd_hi        (rd_hi),
    .soc          (soc),
    .busy         (busy),
    .res_lo       (res_lo),
    .res_hi       (res_hi),
    .auto_evt     (auto_evt),
    .guard_locked (guard_locked)
);

// File: tb/adc_trig_ctrl_test.sv
`timescale 1ns/1ps
module adc_trig_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       auto_en;
    logic [3:0] trig_sel;
    logic [9:0] evt_flag;
    logic [2:0] sync_pulse;
    logic       start_req;
    logic       conv_done;
    logic [9:0] conv_result;
    logic       rd_lo;
    logic       rd_hi;
    logic       soc;
    logic       busy;
    logic [7:0] res_lo;
    logic [7:0] res_hi;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    adc_trig_ctrl uut (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .trig_sel(trig_sel),
        .evt_flag(evt_flag), .sync_pulse(sync_pulse), .start_req(start_req),
        .conv_done(conv_done), .conv_result(conv_result), .rd_lo(rd_lo),
        .rd_hi(rd_hi), .soc(soc), .busy(busy), .res_lo(res_lo), .res_hi(res_hi)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // manual start; returns at the negedge where soc should be high
    task automatic kick();
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    // converter completes; returns at the negedge after the strobe cycle
    task automatic finish_conv(input logic [9:0] v);
        conv_done   = 1'b1;
        conv_result = v;
        @(negedge clk);
        conv_done   = 1'b0;
    endtask

    task automatic pulse_rd(input logic lo);
        if (lo) rd_lo = 1'b1; else rd_hi = 1'b1;
        @(negedge clk);
        rd_lo = 1'b0;
        rd_hi = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "soc", soc, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "res_lo", res_lo, 0);
        chk("R1", "res_hi", res_hi, 0);
    endtask

    task automatic t_manual();
        auto_en = 1'b0; trig_sel = 4'd1; cyc(2);
        evt_flag[0] = 1'b1; cyc(1);
        chk("R2", "soc from flag with auto off", soc, 0);
        cyc(1);
        chk("R2", "soc later", soc, 0);
        evt_flag[0] = 1'b0;
        kick();
        chk("R2", "soc after manual", soc, 1);
        chk("R2", "busy after manual", busy, 1);
        cyc(1);
        chk("R12", "soc one cycle", soc, 0);
        finish_conv(10'h001);
        chk("R2", "busy after done", busy, 0);
    endtask

    task automatic t_flag_edge();
        auto_en = 1'b1; trig_sel = 4'd1; cyc(2);
        evt_flag[3] = 1'b1; cyc(1);
        chk("R3", "unselected flag", soc, 0);
        evt_flag[3] = 1'b0;
        evt_flag[0] = 1'b1; cyc(1);
        chk("R3", "soc on selected edge", soc, 1);
        cyc(2);
        finish_conv(10'h002);
        cyc(3);
        chk("R3", "held flag no restart", soc, 0);
        chk("R3", "held flag idle", busy, 0);
        evt_flag[0] = 1'b0;
        trig_sel = 4'd12; cyc(2);
        evt_flag[8] = 1'b1; cyc(1);
        chk("R3", "comparator2 edge", soc, 1);
        finish_conv(10'h003);
        evt_flag[8] = 1'b0;
        cyc(1);
    endtask

    task automatic t_sync();
        auto_en = 1'b1; trig_sel = 4'd8; cyc(2);
        sync_pulse[1] = 1'b1; cyc(1); sync_pulse[1] = 1'b0;
        chk("R4", "sync start", soc, 1);
        cyc(1);
        sync_pulse[1] = 1'b1; cyc(1); sync_pulse[1] = 1'b0;
        chk("R4", "sync while busy", soc, 0);
        cyc(1);
        chk("R4", "sync while busy later", soc, 0);
        finish_conv(10'h004);
        sync_pulse[0] = 1'b1; cyc(1); sync_pulse[0] = 1'b0;
        chk("R4", "other sync ignored", soc, 0);
        sync_pulse[1] = 1'b1; cyc(1); sync_pulse[1] = 1'b0;
        chk("R4", "sync again after done", soc, 1);
        finish_conv(10'h005);
    endtask

    task automatic t_reserved();
        int hits = 0;
        auto_en = 1'b1;
        for (int c = 14; c < 16; c++) begin
            trig_sel = 4'(c); cyc(2);
            for (int k = 0; k < 4; k++) begin
                evt_flag = (k % 2 == 0) ? 10'h3FF : 10'h000;
                sync_pulse = (k % 2 == 0) ? 3'b111 : 3'b000;
                cyc(1);
                if (soc) hits++;
            end
        end
        evt_flag = '0; sync_pulse = '0; cyc(1);
        if (soc) hits++;
        chk("R5", "starts on reserved codes", hits, 0);
    endtask

    task automatic t_sel_change();
        auto_en = 1'b0; trig_sel = 4'd1;
        evt_flag[0] = 1'b1; evt_flag[4] = 1'b1; cyc(2);
        auto_en = 1'b1; cyc(2);
        trig_sel = 4'd5; cyc(1);
        chk("R6", "switch to high flag", soc, 0);
        cyc(1);
        chk("R6", "switch to high flag later", soc, 0);
        evt_flag[4] = 1'b0; cyc(1);
        evt_flag[4] = 1'b1; cyc(1);
        chk("R6", "fresh edge after switch", soc, 1);
        finish_conv(10'h006);
        evt_flag = '0; cyc(1);
    endtask

    task automatic t_free_run();
        auto_en = 1'b1; trig_sel = 4'd0; cyc(2);
        chk("R7", "no self start", soc, 0);
        kick();
        chk("R7", "manual first start", soc, 1);
        cyc(1);
        finish_conv(10'h007);
        chk("R7", "soc one cycle after strobe", soc, 0);
        cyc(1);
        chk("R7", "relaunch soc", soc, 1);
        chk("R7", "busy after relaunch", busy, 1);
        auto_en = 1'b0; cyc(1);
        finish_conv(10'h008);
        cyc(1);
        chk("R7", "no relaunch when disabled", soc, 0);
        chk("R7", "idle when disabled", busy, 0);
    endtask

    task automatic t_busy_ignore();
        auto_en = 1'b0;
        kick();
        chk("R8", "start accepted", soc, 1);
        cyc(1);
        kick();
        chk("R8", "start while busy", soc, 0);
        finish_conv(10'h009);
        cyc(2);
        chk("R8", "not queued soc", soc, 0);
        chk("R8", "not queued busy", busy, 0);
    endtask

    task automatic t_result();
        kick(); cyc(1);
        finish_conv(10'h2A5);
        chk("R9", "res_lo", res_lo, 8'hA5);
        chk("R9", "res_hi", res_hi, 8'h02);
        finish_conv(10'h15A);
        chk("R9", "res_lo second", res_lo, 8'h5A);
        chk("R9", "res_hi second", res_hi, 8'h01);
    endtask

    task automatic t_lock();
        pulse_rd(1'b1);
        finish_conv(10'h3FF);
        chk("R10", "locked lo", res_lo, 8'h5A);
        chk("R10", "locked hi", res_hi, 8'h01);
        pulse_rd(1'b0);
        finish_conv(10'h0C3);
        chk("R10", "unlocked lo", res_lo, 8'hC3);
        chk("R10", "unlocked hi", res_hi, 8'h00);
        rd_lo = 1'b1;
        finish_conv(10'h1FF);
        rd_lo = 1'b0;
        chk("R10", "same-cycle read drops lo", res_lo, 8'hC3);
        chk("R10", "same-cycle read drops hi", res_hi, 8'h00);
        pulse_rd(1'b0);
    endtask

    task automatic t_hi_only();
        pulse_rd(1'b0);
        finish_conv(10'h2E7);
        chk("R11", "lo after lone hi read", res_lo, 8'hE7);
        chk("R11", "hi after lone hi read", res_hi, 8'h02);
    endtask

    initial begin
        #1000000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; auto_en = 1'b0; trig_sel = '0; evt_flag = '0;
        sync_pulse = '0; start_req = 1'b0; conv_done = 1'b0;
        conv_result = '0; rd_lo = 1'b0; rd_hi = 1'b0;
        cyc(3);
        t_reset();
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_manual();
        t_flag_edge();
        t_sync();
        t_reserved();
        t_sel_change();
        t_free_run();
        t_busy_ignore();
        t_result();
        t_lock();
        t_hi_only();
        cyc(2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule